// File: doc/BRIEF.md
# Huff-Puff Frequency Lock Detector

This block holds a free-running oscillator on one of a comb of evenly spaced lock points. It needs no reference oscillator and no frequency counter. The oscillator drives a divide-by-two toggle that runs in the oscillator's own clock domain. A two-flop synchroniser brings the toggle state into the system clock domain. A divider produces one sample tick every `SAMPLE_DIV` system clock cycles.

On each tick the synchronised toggle bit is captured and pushed into a `TAPS`-stage serial delay line. The same bit is compared with the sample that has travelled the whole line. The one-bit correction output goes high when the two agree and low when they differ. An external analog integrator turns this output into the tuning voltage of the oscillator.

The adjacent lock points lie 2·f_sample / TAPS apart. The defaults are 2000 cycles of a 20 MHz clock (a 10 kHz sample rate) and 1000 stages, which give a spacing of 20 Hz. A one-cycle `sample_tick` output marks each refresh of the correction bit.

Top module: `drift_lock_det`

## Requirements
- R1: While `rst_n` is low, `corr_out` is 1 and `sample_tick` is 0. Reset clears the toggle, the synchroniser, the tick divider and every stage of the delay line.
- R2: `sample_tick` is a pulse one cycle wide, and consecutive pulses are exactly `SAMPLE_DIV` system clock cycles apart.
- R3: The captured sample equals the parity of the oscillator rising edges since reset (0 for an even count, 1 for an odd count), provided the last edge came at least three system clock edges before the tick.
- R4: On each tick, `corr_out` becomes 1 when the newest sample equals the sample captured `TAPS` ticks earlier, and 0 when they differ.
- R5: Samples from before the last reset count as 0, so for the first `TAPS` ticks after reset `corr_out` is the inverse of the newest sample.
- R6: `corr_out` changes only on the clock edge that raises `sample_tick`, and it holds its value in every other cycle.
- R7: Oscillator pulses that are shorter than one system clock period, several of them within one clock cycle, are all counted by the toggle.
- R8: In the cycle in which `sample_tick` is 1, `corr_out` already shows the value computed at that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| osc_in | input | 1 | Oscillator signal; its rising edges clock the divide-by-two toggle |
| corr_out | output | 1 | Correction bit to the integrator: 1 when matched, 0 when mismatched |
| sample_tick | output | 1 | One-cycle pulse marking the cycle in which corr_out was refreshed |

## Verification
An oscillator edge reaches the sampler two system clock edges after the toggle flips. The tick edge updates `corr_out` and raises `sample_tick` together, so both results are visible in the cycle after the tick edge. The bench drives its oscillator pulses just after each observed tick, which leaves about `SAMPLE_DIV` cycles of margin before the next capture. At every falling edge it checks that `corr_out` has not moved outside tick cycles and that the tick spacing is exact. It compares each refreshed `corr_out` with a delay-line model of its own, sampling on the falling edge of the cycle in which `sample_tick` is high.

// File: rtl/drift_lock_pkg.sv
package drift_lock_pkg;

  // Default tick divisor: system clock cycles per sample period.
  localparam int unsigned DL_SAMPLE_DIV_DEF = 2000;
  // Default number of delay-line stages.
  localparam int unsigned DL_TAPS_DEF       = 1000;

  // Width of a counter that must hold the values 0 .. n-1.
  function automatic int unsigned dl_cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/dl_sync2.sv
// Two-flop synchroniser with asynchronous clear. The reset release chain
// and the oscillator-bit crossing both use it.
module dl_sync2 #(
  parameter logic CLR_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= CLR_VAL;
      hold_q <= CLR_VAL;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;

endmodule

// File: rtl/dl_osc_halver.sv
// Divide-by-two toggle clocked by the oscillator itself.
module dl_osc_halver (
  input  logic osc_clk,
  input  logic arst_n,
  output logic half_q
);

  logic tog_q;
  logic tog_d;

  always_comb begin
    tog_d = ~tog_q;
  end

  always_ff @(posedge osc_clk or negedge arst_n) begin
    if (!arst_n) begin
      tog_q <= 1'b0;
    end else begin
      tog_q <= tog_d;
    end
  end

  assign half_q = tog_q;

endmodule

// File: rtl/dl_tick_gen.sv
// Free-running modulo-DIV counter. tick is high in the last count state.
module dl_tick_gen
  import drift_lock_pkg::*;
#(
  parameter int unsigned DIV = DL_SAMPLE_DIV_DEF
) (
  input  logic clk,
  input  logic arst_n,
  output logic tick
);

  localparam int unsigned CW = dl_cnt_w(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          wrap;

  generate
    if (DIV < 2) begin : g_every
      always_comb begin
        wrap  = 1'b1;
        cnt_d = '0;
      end
    end else begin : g_count
      always_comb begin
        wrap  = (cnt_q == LAST);
        cnt_d = wrap ? '0 : (cnt_q + ONE);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = wrap;

endmodule

// File: rtl/dl_tap_line.sv
// Serial delay line of TAPS stages that shifts only when shift_en is high.
// far_bit is the sample that entered TAPS shifts ago.
module dl_tap_line
  import drift_lock_pkg::*;
#(
  parameter int unsigned TAPS = DL_TAPS_DEF
) (
  input  logic clk,
  input  logic arst_n,
  input  logic shift_en,
  input  logic din,
  output logic far_bit
);

  logic [TAPS-1:0] line_q;
  logic [TAPS-1:0] line_d;

  generate
    if (TAPS == 1) begin : g_single
      always_comb begin
        line_d = shift_en ? din : line_q;
      end
    end else begin : g_chain
      always_comb begin
        if (shift_en) begin
          line_d = {line_q[TAPS-2:0], din};
        end else begin
          line_d = line_q;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      line_q <= '0;
    end else begin
      line_q <= line_d;
    end
  end

  assign far_bit = line_q[TAPS-1];

endmodule

// File: rtl/drift_lock_det.sv
// Top level: toggle, crossing, tick divider, delay line and the
// correction register.
module drift_lock_det
  import drift_lock_pkg::*;
#(
  parameter int unsigned SAMPLE_DIV = DL_SAMPLE_DIV_DEF,
  parameter int unsigned TAPS       = DL_TAPS_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_in,
  output logic corr_out,
  output logic sample_tick
);

  logic rst_int_n;
  logic half_osc;
  logic half_sync;
  logic tick;
  logic far_bit;
  logic corr_q;
  logic corr_d;
  logic tick_q;
  logic tick_d;

  // Reset: asynchronous assertion, release aligned to clk.
  dl_sync2 #(.CLR_VAL(1'b0)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .d      (1'b1),
    .q      (rst_int_n)
  );

  dl_osc_halver u_halver (
    .osc_clk (osc_in),
    .arst_n  (rst_int_n),
    .half_q  (half_osc)
  );

  dl_sync2 #(.CLR_VAL(1'b0)) u_bit_sync (
    .clk    (clk),
    .arst_n (rst_int_n),
    .d      (half_osc),
    .q      (half_sync)
  );

  dl_tick_gen #(.DIV(SAMPLE_DIV)) u_tick (
    .clk    (clk),
    .arst_n (rst_int_n),
    .tick   (tick)
  );

  dl_tap_line #(.TAPS(TAPS)) u_line (
    .clk      (clk),
    .arst_n   (rst_int_n),
    .shift_en (tick),
    .din      (half_sync),
    .far_bit  (far_bit)
  );

  // Newest sample against the one that left the far end of the line.
  always_comb begin
    tick_d = tick;
    if (tick) begin
      corr_d = ~(half_sync ^ far_bit);
    end else begin
      corr_d = corr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      corr_q <= 1'b1;
      tick_q <= 1'b0;
    end else begin
      corr_q <= corr_d;
      tick_q <= tick_d;
    end
  end

  assign corr_out    = corr_q;
  assign sample_tick = tick_q;

endmodule

// File: rtl/dl_lock_chk.sv
// Port-level properties of the lock detector.
module dl_lock_chk
  import drift_lock_pkg::*;
#(
  parameter int unsigned SAMPLE_DIV = DL_SAMPLE_DIV_DEF
) (
  input logic clk,
  input logic rst_n,
  input logic corr_out,
  input logic sample_tick
);

  localparam int unsigned GW = dl_cnt_w(SAMPLE_DIV) + 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(SAMPLE_DIV - 1);

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (sample_tick) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q  <= gap_q + GW'(1);
    end
  end

  AST_RESET_MATCHED: assert property (@(posedge clk)
    !rst_n |=> (corr_out && !sample_tick)); // R1

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && seen_q) |-> (gap_q == GAP_LAST)); // R2

  AST_CORR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |-> $stable(corr_out)); // R6

  generate
    if (SAMPLE_DIV >= 2) begin : g_pulse
      AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |=> !sample_tick); // R2
    end
  endgenerate

endmodule

bind drift_lock_det dl_lock_chk #(.SAMPLE_DIV(SAMPLE_DIV)) u_lock_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .corr_out    (corr_out),
  .sample_tick (sample_tick)
);

// File: tb/drift_lock_det_bench.sv
module drift_lock_det_bench;

  localparam int DIV  = 10;
  localparam int TAPS = 20;

  logic clk;
  logic rst_n;
  logic osc_in;
  logic corr_out;
  logic sample_tick;

  int checks;
  int errors;
  logic t_par;
  logic [TAPS-1:0] hist;
  logic first_step;
  logic [7:0] lfsr;

  drift_lock_det #(.SAMPLE_DIV(DIV), .TAPS(TAPS)) u_drift_lock_det (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_in      (osc_in),
    .corr_out    (corr_out),
    .sample_tick (sample_tick)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R7: 1 ns pulses, several inside one 20 ns clock period.
  task automatic fire_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      osc_in = 1'b1;
      #1;
      osc_in = 1'b0;
      #1;
      t_par = ~t_par;
    end
  endtask

  // Called at a falling edge just after a tick (or after reset).
  task automatic step(input int n, input string req);
    int gap;
    logic held;
    logic exp;
    fire_pulses(n);
    held = corr_out;
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
      if (!sample_tick) chk_bit("R6 hold", corr_out, held);
    end while (!sample_tick && gap < 4 * DIV);
    if (!first_step) chk_int("R2 tick spacing", gap, DIV);
    first_step = 1'b0;
    exp = ~(t_par ^ hist[TAPS-1]);
    chk_bit(req, corr_out, exp);
    hist = {hist[TAPS-2:0], t_par};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    osc_in = 1'b0;
    repeat (3) @(negedge clk);
    chk_bit("R1 corr in reset", corr_out, 1'b1);
    chk_bit("R1 tick in reset", sample_tick, 1'b0);
    rst_n = 1'b1;
    t_par = 1'b0;
    hist = '0;
    first_step = 1'b1;
  endtask

  task automatic test_idle();
    do_reset();
    for (int i = 0; i < TAPS + 4; i++) step(0, "R4 R5 R8 idle");
  endtask

  task automatic test_single_flip();
    step(1, "R3 R5 single edge");
    chk_bit("R5 mismatch after flip", corr_out, 1'b0);
    for (int i = 0; i < TAPS + 3; i++) step(0, "R4 after flip");
  endtask

  task automatic test_alternate();
    for (int i = 0; i < 2 * TAPS; i++) step(1, "R4 alternate lock");
  endtask

  task automatic test_random();
    for (int i = 0; i < 3 * TAPS; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(int'(lfsr[1:0]), "R3 R4 R7 random");
    end
  endtask

  task automatic test_fast();
    for (int i = 0; i < TAPS + 5; i++) step((i % 3 == 0) ? 3 : 2, "R7 burst");
  endtask

  task automatic test_reset_clears();
    if (t_par == 1'b0) step(1, "R4 prep");
    for (int i = 0; i < TAPS + 2; i++) step(0, "R4 fill ones");
    do_reset();
    for (int i = 0; i < TAPS; i++) step(0, "R1 R5 cleared line");
    step(1, "R5 first flip after reset");
    chk_bit("R5 inverse of newest", corr_out, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    osc_in = 1'b0;
    t_par = 1'b0;
    hist = '0;
    first_step = 1'b1;
    lfsr = 8'hA5;
    test_idle();
    test_single_flip();
    test_alternate();
    test_random();
    test_fast();
    test_reset_clears();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule